// File: doc/BRIEF.md
# Decoder Initialization Sequencer

This block orders the start-up and flush activity of a streaming audio decoder. Three events can start a sequence. The first is the external active-low reset pin. The second is a host write that asks for a reset. The third is a host write that asks for a restart, which only flushes the data buffers. Each kind clears a different set of host-visible registers and runs a different subset of steps. The steps are external memory refresh cycling, a buffer-clear handshake, and a probe for external memory presence and size.

While a sequence runs, the data-request output stays high and the host may not push stream data. The buffer store, memory controller and decoder datapath sit outside the block. The block starts each step and waits for it. Buffer clearing ends through a request/done handshake. Refresh and probe lengths are parameters. The defaults match roughly 0.7 ms and 3.7 ms of total reset time at a 24 MHz clock.

Top module: `init_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released: `data_req_o`=1, `rst_stat_o`=1, `rstrt_stat_o`=0, `play_o`=0, `mute_o`=0, `clkdiv_o`=DIV_RST, and `int_en_o`, `intr_o` and `buf_stat_o` are zero. Host writes made while `rst_n` is low change nothing.
- R2: After the pin is released, the steps run in this order: refresh (`refresh_o` high for exactly REFRESH_CYC cycles), then buffer clear, then probe (`probe_o` high for exactly PROBE_CYC cycles), then finish.
- R3: `buf_clr_o` stays high, and the sequence does not advance, until `buf_clr_done_i` is seen high during a clear.
- R4: `mem_present_i` and `mem_size_i` are captured on the last probe cycle and shown on `mem_present_o`/`mem_size_o`. They do not change at any other time.
- R5: A host write to address 4 (register reset) sets `rst_stat_o` and `data_req_o` and clears `intr_o`, `int_en_o` and `buf_stat_o`. It runs the clear and probe steps but no refresh. `play_o`, `mute_o` and `clkdiv_o` keep their values.
- R6: A host write to address 5 (restart) sets `rstrt_stat_o` and `data_req_o` and clears `intr_o`, `int_en_o` and `buf_stat_o`. It runs only the buffer clear: no refresh and no probe. Play, mute, clock divider and the memory results are kept.
- R7: Every sequence ends by dropping `data_req_o` and clearing both status outputs in the same cycle. While `data_req_o` is high, at least one status output is high.
- R8: `data_ack_o` = `data_wr_i` AND NOT `data_req_o`.
- R9: Host writes go to address 0 (`int_en_o` ← wdata[IRQ_W-1:0]), 1 (`play_o` ← wdata[0]), 2 (`mute_o` ← wdata[0]) and 3 (`clkdiv_o` ← wdata[DIV_W-1:0]). These writes take effect during a register reset or restart as well as when idle.
- R10: A pin reset aborts any sequence and starts the full pin sequence. A restart request that arrives while any sequence is running is ignored. A register-reset request that arrives during a restart's clear or finish step turns it into a register reset. A register-reset request during a reset is ignored.
- R11: Each high bit of `irq_evt_i` sets the matching bit of `intr_o`, and `buf_evt_i` sets `buf_stat_o`. Both are sticky until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset pin, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| data_wr_i | input | 1 | Stream data write attempt |
| irq_evt_i | input | IRQ_W | Interrupt event pulses |
| buf_evt_i | input | 1 | Buffer status event pulse |
| buf_clr_done_i | input | 1 | Buffer clear finished |
| mem_present_i | input | 1 | Probe result: memory present |
| mem_size_i | input | SIZE_W | Probe result: memory size code |
| data_req_o | output | 1 | High while a sequence runs |
| data_ack_o | output | 1 | Stream data write accepted |
| rst_stat_o | output | 1 | Reset status |
| rstrt_stat_o | output | 1 | Restart status |
| int_en_o | output | IRQ_W | Interrupt enable register |
| intr_o | output | IRQ_W | Interrupt request register |
| buf_stat_o | output | 1 | Buffer status register |
| play_o | output | 1 | Play control |
| mute_o | output | 1 | Mute control |
| clkdiv_o | output | DIV_W | Audio clock divider |
| refresh_o | output | 1 | Memory refresh cycling active |
| buf_clr_o | output | 1 | Buffer clear request |
| probe_o | output | 1 | Memory probe active |
| mem_present_o | output | 1 | Stored memory presence |
| mem_size_o | output | SIZE_W | Stored memory size code |

## Verification
A wrong step order or a skipped step shows up as wrong counts of `refresh_o` and `probe_o` high cycles between the start of a sequence and the fall of `data_req_o`. It also shows as the wrong sample appearing on the memory result outputs once the sequence ends. A kind recorded wrongly inside the block shows within one cycle of the request. The status outputs, or which registers were cleared and which were kept, do not match the request. A stalled handshake leaves `data_req_o` high, so stream writes stay refused.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE    = 5'b00001,
        ST_REFRESH = 5'b00010,
        ST_CLEAR   = 5'b00100,
        ST_PROBE   = 5'b01000,
        ST_FINISH  = 5'b10000
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_PIN   = 2'd0,
        CAUSE_REG   = 2'd1,
        CAUSE_FLUSH = 2'd2
    } seq_cause_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = len_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
    import init_seq_pkg::*;
#(
    parameter int unsigned REFRESH_CYC = 72000,
    parameter int unsigned PROBE_CYC   = 16800,
    parameter int unsigned SIZE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_req_i,
    input  logic              flush_req_i,
    input  logic              buf_clr_done_i,
    input  logic              mem_present_i,
    input  logic [SIZE_W-1:0] mem_size_i,
    output logic              seq_start_o,
    output logic              data_req_o,
    output logic              rst_stat_o,
    output logic              rstrt_stat_o,
    output logic              refresh_o,
    output logic              buf_clr_o,
    output logic              probe_o,
    output logic              mem_present_o,
    output logic [SIZE_W-1:0] mem_size_o
);

    localparam int unsigned MAX_CYC = (REFRESH_CYC > PROBE_CYC) ? REFRESH_CYC : PROBE_CYC;
    localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        seq_cause_e        cause;
        logic              rst_stat;
        logic              rstrt;
        logic              mem_pres;
        logic [SIZE_W-1:0] mem_size;
    } fsm_t;

    fsm_t       s_d, s_q;
    logic       tmr_load, tmr_done;
    logic       start_d;

    seq_timer #(
        .W       (TMR_W),
        .RST_VAL (REFRESH_CYC - 1)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (TMR_W'(PROBE_CYC - 1)),
        .done_o (tmr_done)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        start_d  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (soft_req_i) begin
                    s_d.st       = ST_CLEAR;
                    s_d.cause    = CAUSE_REG;
                    s_d.rst_stat = 1'b1;
                    start_d      = 1'b1;
                end else if (flush_req_i) begin
                    s_d.st    = ST_CLEAR;
                    s_d.cause = CAUSE_FLUSH;
                    s_d.rstrt = 1'b1;
                    start_d   = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (tmr_done) s_d.st = ST_CLEAR;
            end
            ST_CLEAR, ST_FINISH: begin
                if (soft_req_i && s_q.cause == CAUSE_FLUSH) begin
                    s_d.st       = ST_CLEAR;
                    s_d.cause    = CAUSE_REG;
                    s_d.rst_stat = 1'b1;
                    s_d.rstrt    = 1'b0;
                    start_d      = 1'b1;
                end else if (s_q.st == ST_FINISH) begin
                    s_d.st       = ST_IDLE;
                    s_d.rst_stat = 1'b0;
                    s_d.rstrt    = 1'b0;
                end else if (buf_clr_done_i) begin
                    if (s_q.cause == CAUSE_FLUSH) begin
                        s_d.st = ST_FINISH;
                    end else begin
                        s_d.st   = ST_PROBE;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_PROBE: begin
                if (tmr_done) begin
                    s_d.st       = ST_FINISH;
                    s_d.mem_pres = mem_present_i;
                    s_d.mem_size = mem_size_i;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_REFRESH;
            s_q.cause    <= CAUSE_PIN;
            s_q.rst_stat <= 1'b1;
            s_q.rstrt    <= 1'b0;
            s_q.mem_pres <= 1'b0;
            s_q.mem_size <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign seq_start_o   = start_d;
    assign data_req_o    = (s_q.st != ST_IDLE);
    assign rst_stat_o    = s_q.rst_stat;
    assign rstrt_stat_o  = s_q.rstrt;
    assign refresh_o     = (s_q.st == ST_REFRESH);
    assign buf_clr_o     = (s_q.st == ST_CLEAR);
    assign probe_o       = (s_q.st == ST_PROBE);
    assign mem_present_o = s_q.mem_pres;
    assign mem_size_o    = s_q.mem_size;

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(s_q.st)); // R2
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(s_q.rst_stat && s_q.rstrt)); // R10
    AST_BUSY_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (s_q.st != ST_IDLE) |-> (s_q.rst_stat || s_q.rstrt)); // R7
    AST_REFRESH_PIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (s_q.st == ST_REFRESH) |-> (s_q.cause == CAUSE_PIN)); // R5
    AST_FLUSH_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n) (s_q.st == ST_PROBE) |-> (s_q.cause != CAUSE_FLUSH)); // R6
    AST_CLEAR_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (s_q.st == ST_CLEAR && !buf_clr_done_i) |=> (s_q.st == ST_CLEAR)); // R3
    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n) (s_q.st != ST_PROBE) |=> ($stable(s_q.mem_size) && $stable(s_q.mem_pres))); // R4

endmodule

// File: rtl/init_seq_regs.sv
module init_seq_regs #(
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IRQ_W   = 4,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned DIV_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              seq_start_i,
    input  logic [IRQ_W-1:0]  irq_evt_i,
    input  logic              buf_evt_i,
    output logic              soft_req_o,
    output logic              flush_req_o,
    output logic [IRQ_W-1:0]  int_en_o,
    output logic [IRQ_W-1:0]  intr_o,
    output logic              buf_stat_o,
    output logic              play_o,
    output logic              mute_o,
    output logic [DIV_W-1:0]  clkdiv_o
);

    localparam logic [ADDR_W-1:0] A_INT_EN = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PLAY   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MUTE   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CLKDIV = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_SOFT   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_FLUSH  = ADDR_W'(5);

    typedef struct packed {
        logic [IRQ_W-1:0] int_en;
        logic [IRQ_W-1:0] intr;
        logic             buf_stat;
        logic             play;
        logic             mute;
        logic [DIV_W-1:0] clkdiv;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (seq_start_i) begin
            r_d.intr     = '0;
            r_d.int_en   = '0;
            r_d.buf_stat = 1'b0;
        end else begin
            r_d.intr     = r_q.intr | irq_evt_i;
            r_d.buf_stat = r_q.buf_stat | buf_evt_i;
        end
        if (host_wr_i) begin
            unique case (host_addr_i)
                A_INT_EN: r_d.int_en = host_wdata_i[IRQ_W-1:0];
                A_PLAY:   r_d.play   = host_wdata_i[0];
                A_MUTE:   r_d.mute   = host_wdata_i[0];
                A_CLKDIV: r_d.clkdiv = host_wdata_i[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.int_en   <= '0;
            r_q.intr     <= '0;
            r_q.buf_stat <= 1'b0;
            r_q.play     <= 1'b0;
            r_q.mute     <= 1'b0;
            r_q.clkdiv   <= DIV_W'(DIV_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign soft_req_o  = host_wr_i && (host_addr_i == A_SOFT);
    assign flush_req_o = host_wr_i && (host_addr_i == A_FLUSH);
    assign int_en_o    = r_q.int_en;
    assign intr_o      = r_q.intr;
    assign buf_stat_o  = r_q.buf_stat;
    assign play_o      = r_q.play;
    assign mute_o      = r_q.mute;
    assign clkdiv_o    = r_q.clkdiv;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) seq_start_i |=> (r_q.intr == '0 && r_q.int_en == '0 && !r_q.buf_stat)); // R5
    AST_START_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n) seq_start_i |=> ($stable(r_q.play) && $stable(r_q.mute) && $stable(r_q.clkdiv))); // R6

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer #(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IRQ_W       = 4,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned DIV_RST     = 4,
    parameter int unsigned SIZE_W      = 2,
    parameter int unsigned REFRESH_CYC = 72000,
    parameter int unsigned PROBE_CYC   = 16800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              data_wr_i,
    input  logic [IRQ_W-1:0]  irq_evt_i,
    input  logic              buf_evt_i,
    input  logic              buf_clr_done_i,
    input  logic              mem_present_i,
    input  logic [SIZE_W-1:0] mem_size_i,
    output logic              data_req_o,
    output logic              data_ack_o,
    output logic              rst_stat_o,
    output logic              rstrt_stat_o,
    output logic [IRQ_W-1:0]  int_en_o,
    output logic [IRQ_W-1:0]  intr_o,
    output logic              buf_stat_o,
    output logic              play_o,
    output logic              mute_o,
    output logic [DIV_W-1:0]  clkdiv_o,
    output logic              refresh_o,
    output logic              buf_clr_o,
    output logic              probe_o,
    output logic              mem_present_o,
    output logic [SIZE_W-1:0] mem_size_o
);

    logic soft_req, flush_req, seq_start;

    init_seq_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IRQ_W   (IRQ_W),
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .seq_start_i  (seq_start),
        .irq_evt_i    (irq_evt_i),
        .buf_evt_i    (buf_evt_i),
        .soft_req_o   (soft_req),
        .flush_req_o  (flush_req),
        .int_en_o     (int_en_o),
        .intr_o       (intr_o),
        .buf_stat_o   (buf_stat_o),
        .play_o       (play_o),
        .mute_o       (mute_o),
        .clkdiv_o     (clkdiv_o)
    );

    init_seq_fsm #(
        .REFRESH_CYC (REFRESH_CYC),
        .PROBE_CYC   (PROBE_CYC),
        .SIZE_W      (SIZE_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_req_i     (soft_req),
        .flush_req_i    (flush_req),
        .buf_clr_done_i (buf_clr_done_i),
        .mem_present_i  (mem_present_i),
        .mem_size_i     (mem_size_i),
        .seq_start_o    (seq_start),
        .data_req_o     (data_req_o),
        .rst_stat_o     (rst_stat_o),
        .rstrt_stat_o   (rstrt_stat_o),
        .refresh_o      (refresh_o),
        .buf_clr_o      (buf_clr_o),
        .probe_o        (probe_o),
        .mem_present_o  (mem_present_o),
        .mem_size_o     (mem_size_o)
    );

    assign data_ack_o = data_wr_i && !data_req_o;

endmodule

// File: tb/init_sequencer_tb.sv
module init_sequencer_tb;

    localparam int unsigned REF_C  = 20;
    localparam int unsigned PRB_C  = 10;
    localparam int unsigned DIV_RV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       data_wr = 1'b1;
    logic [3:0] irq_evt = '0;
    logic       buf_evt = 1'b0;
    logic       clr_done = 1'b0;
    logic       mem_pres = 1'b1;
    logic [1:0] mem_sz = 2'd3;

    logic       data_req, data_ack, rst_stat, rstrt_stat, buf_stat, play, mute;
    logic       refresh, buf_clr, probe, mem_pres_o;
    logic [3:0] int_en, intr;
    logic [7:0] clkdiv;
    logic [1:0] mem_sz_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_ref = 0, n_prb = 0, n_clr = 0;
    int saw_rstrt = 0;
    int clr_lat = 5;
    int stub_cnt = 0;

    init_sequencer #(
        .DIV_RST     (DIV_RV),
        .REFRESH_CYC (REF_C),
        .PROBE_CYC   (PRB_C)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr_i      (host_wr),
        .host_addr_i    (host_addr),
        .host_wdata_i   (host_wdata),
        .data_wr_i      (data_wr),
        .irq_evt_i      (irq_evt),
        .buf_evt_i      (buf_evt),
        .buf_clr_done_i (clr_done),
        .mem_present_i  (mem_pres),
        .mem_size_i     (mem_sz),
        .data_req_o     (data_req),
        .data_ack_o     (data_ack),
        .rst_stat_o     (rst_stat),
        .rstrt_stat_o   (rstrt_stat),
        .int_en_o       (int_en),
        .intr_o         (intr),
        .buf_stat_o     (buf_stat),
        .play_o         (play),
        .mute_o         (mute),
        .clkdiv_o       (clkdiv),
        .refresh_o      (refresh),
        .buf_clr_o      (buf_clr),
        .probe_o        (probe),
        .mem_present_o  (mem_pres_o),
        .mem_size_o     (mem_sz_o)
    );

    always #2 clk = ~clk;

    // monitor and buffer-clear stub, both on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (refresh)    n_ref++;
            if (probe)      n_prb++;
            if (buf_clr)    n_clr++;
            if (rstrt_stat) saw_rstrt = 1;
        end
        if (buf_clr && !clr_done) begin
            stub_cnt++;
            if (stub_cnt >= clr_lat) clr_done = 1'b1;
        end else begin
            clr_done = 1'b0;
            stub_cnt = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_ref = 0; n_prb = 0; n_clr = 0; saw_rstrt = 0;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!data_req) break;
        end
    endtask

    task automatic t_pin_reset();
        clear_counts();
        clr_lat = 40;
        rst_n = 1'b0;
        host_write(3'd1, 8'h01); // write while pin low: ignored
        @(negedge clk);
        chk("R1 data_req", data_req, 1);
        chk("R1 rst_stat", rst_stat, 1);
        chk("R1 rstrt_stat", rstrt_stat, 0);
        chk("R1 play", play, 0);
        chk("R1 mute", mute, 0);
        chk("R1 clkdiv", clkdiv, DIV_RV);
        chk("R1 int_en", int_en, 0);
        chk("R1 intr", intr, 0);
        chk("R1 buf_stat", buf_stat, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data_req after release", data_req, 1);
        chk("R8 ack refused while busy", data_ack, 0);
        wait_idle();
        chk("R2 refresh cycles", n_ref, REF_C);
        chk("R2 probe cycles", n_prb, PRB_C);
        chk("R3 clear waits for done", n_clr, 40);
        chk("R4 mem present", mem_pres_o, 1);
        chk("R4 mem size", mem_sz_o, 3);
        chk("R7 rst_stat cleared", rst_stat, 0);
        chk("R7 data_req low", data_req, 0);
        chk("R8 ack when idle", data_ack, 1);
    endtask

    task automatic t_host_regs();
        host_write(3'd0, 8'h0A);
        host_write(3'd1, 8'h01);
        host_write(3'd2, 8'h01);
        host_write(3'd3, 8'h09);
        @(posedge clk); #1;
        irq_evt = 4'b0100; buf_evt = 1'b1;
        @(posedge clk); #1;
        irq_evt = 4'b0000; buf_evt = 1'b0;
        @(negedge clk);
        chk("R9 int_en", int_en, 8'h0A & 8'h0F);
        chk("R9 play", play, 1);
        chk("R9 mute", mute, 1);
        chk("R9 clkdiv", clkdiv, 9);
        chk("R11 intr sticky", intr, 4);
        chk("R11 buf_stat", buf_stat, 1);
    endtask

    task automatic t_restart();
        clear_counts();
        clr_lat = 8;
        mem_pres = 1'b0; mem_sz = 2'd0;
        host_write(3'd5, 8'h00);
        @(negedge clk);
        chk("R6 rstrt_stat", rstrt_stat, 1);
        chk("R6 rst_stat", rst_stat, 0);
        chk("R6 data_req", data_req, 1);
        chk("R6 intr cleared", intr, 0);
        chk("R6 int_en cleared", int_en, 0);
        chk("R6 buf_stat cleared", buf_stat, 0);
        chk("R6 play kept", play, 1);
        chk("R6 clkdiv kept", clkdiv, 9);
        chk("R8 ack refused in restart", data_ack, 0);
        host_write(3'd0, 8'h05);
        wait_idle();
        chk("R6 no refresh", n_ref, 0);
        chk("R6 no probe", n_prb, 0);
        chk("R6 mem kept", mem_pres_o, 1);
        chk("R9 write during restart", int_en, 5);
        chk("R7 rstrt cleared", rstrt_stat, 0);
    endtask

    task automatic t_soft_reset();
        clear_counts();
        clr_lat = 5;
        mem_pres = 1'b1; mem_sz = 2'd2;
        host_write(3'd4, 8'h00);
        @(negedge clk);
        chk("R5 rst_stat", rst_stat, 1);
        chk("R5 data_req", data_req, 1);
        chk("R5 int_en cleared", int_en, 0);
        chk("R5 mute kept", mute, 1);
        chk("R5 clkdiv kept", clkdiv, 9);
        wait_idle();
        chk("R5 no refresh", n_ref, 0);
        chk("R5 probe cycles", n_prb, PRB_C);
        chk("R4 new mem size", mem_sz_o, 2);
        chk("R7 rst_stat cleared", rst_stat, 0);
    endtask

    task automatic t_restart_ignored();
        clear_counts();
        clr_lat = 6;
        host_write(3'd4, 8'h00);
        host_write(3'd5, 8'h00);
        wait_idle();
        chk("R10 restart ignored in reset", saw_rstrt, 0);
        chk("R10 reset still probes", n_prb, PRB_C);
    endtask

    task automatic t_convert();
        clear_counts();
        clr_lat = 20;
        host_write(3'd5, 8'h00);
        repeat (3) @(posedge clk);
        host_write(3'd4, 8'h00);
        @(negedge clk);
        chk("R10 converted rst_stat", rst_stat, 1);
        chk("R10 converted rstrt", rstrt_stat, 0);
        wait_idle();
        chk("R10 converted probes", n_prb, PRB_C);
        chk("R10 converted no refresh", n_ref, 0);
    endtask

    task automatic t_pin_abort();
        clr_lat = 40;
        host_write(3'd5, 8'h00);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b0;
        clear_counts();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 abort rstrt", rstrt_stat, 0);
        chk("R10 abort rst_stat", rst_stat, 1);
        chk("R10 abort play", play, 0);
        chk("R10 abort clkdiv", clkdiv, DIV_RV);
        @(posedge clk); #1;
        rst_n = 1'b1;
        wait_idle();
        chk("R10 abort full refresh", n_ref, REF_C);
        chk("R10 abort full probe", n_prb, PRB_C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_pin_reset();
        t_host_regs();
        t_restart();
        t_soft_reset();
        t_restart_ignored();
        t_convert();
        t_pin_abort();
        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule